// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits beside the processor's pipeline control. Each cycle it looks at a pending exception and an external interrupt request. It decides whether the processor enters a handler, asks for a system reset, or does nothing. When it enters, it computes every architectural state change at once: the saved copies of the status word, the return address and the stack pointer; the new status word; the event code register; and the handler address.

The core drives the exception code, the interrupt request, the current status word, PC, R15, the vector base and its delay-slot and sleep flags. The interrupt controller receives the current mask level and answers with a vector code and a valid flag. The results are registered. They appear together with a one-cycle `take` pulse, and all of them commit on the same clock edge. Otherwise they hold their last values.

Status-word bit positions: BL (block) is bit 28, RB (register bank) is bit 29, MD (privileged mode) is bit 30, FD (FPU disable) is bit 15, and the interrupt mask level is bits 7:4.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When an exception and an interrupt are both pending in the same cycle, the exception is taken: its code is written to `expevt` and `intevt` keeps its old value.
- R2: With SR bit 28 set, an exception whose code is not 0x1E0 produces a one-cycle `reset_req` and no `take`. Code 0x1E0 is entered normally even with bit 28 set.
- R3: With SR bit 28 set, an interrupt request is ignored (no `take`, no `reset_req`, no `sleep_clr`) unless `sleeping` is high.
- R4: `imask_lvl` always equals SR bits 7:4. An interrupt that would otherwise be taken is dropped when `irq_vec_valid` is low.
- R5: On entry, `ssr` takes the incoming SR, `sgr` takes R15, `resv_clr` pulses, and the new SR is the old one with bits 28, 29 and 30 set.
- R6: On entry while `in_dslot` is high, `spc` is PC minus 2 and `dslot_clr` pulses. Otherwise `spc` is PC and `dslot_clr` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 jump to 0xA0000000, clear SR bit 15 and set SR bits 7:4 to 0xF.
- R8: Exception codes 0x040 and 0x060 jump to VBR+0x400. All other exceptions jump to VBR+0x100. For code 0x160, `spc` is advanced by a further 2 after any delay-slot adjustment.
- R9: A taken interrupt writes the controller's vector to `intevt`, leaves `expevt` unchanged and jumps to VBR+0x600.
- R10: An interrupt request is not accepted while `in_dslot` is high.
- R11: The registered outputs change only on the edge that ends a cycle with `take`. `take`, `reset_req`, `sleep_clr`, `dslot_clr` and `resv_clr` are single-cycle pulses that follow that edge.
- R12: `sleep_clr` pulses whenever an exception or an accepted interrupt gets past the block-bit checks. This includes an interrupt then dropped for lack of a valid vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | External interrupt request |
| irq_vec_valid | input | 1 | Interrupt controller has an acceptable vector |
| irq_vec | input | 12 | Vector code from the interrupt controller |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Address of the current instruction |
| r15_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector base |
| in_dslot | input | 1 | Current instruction is in a delay slot |
| sleeping | input | 1 | Core is in sleep |
| imask_lvl | output | 4 | Mask level for the interrupt controller |
| take | output | 1 | Entry committed on the last edge |
| reset_req | output | 1 | Masked exception turned into a reset |
| sleep_clr | output | 1 | Clear the sleep state |
| dslot_clr | output | 1 | Clear the delay-slot flag |
| resv_clr | output | 1 | Drop the load-linked reservation |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved return address |
| sgr | output | 32 | Saved stack pointer |
| sr_out | output | 32 | New status word |
| pc_out | output | 32 | Handler address |
| expevt | output | 12 | Last exception code entered |
| intevt | output | 12 | Last interrupt vector entered |

## Verification
On every cycle, the assertions check these properties:
- An exception with the block bit clear is entered and not reported as an interrupt.
- A blocked exception becomes a reset request and never an entry.
- A delay-slot interrupt is refused.
- The saved status word and the new block, bank and mode bits agree with the previous cycle's status input.
- `take` and `reset_req` never pulse together.

Only the bench's scenarios can show the handler address chosen for each code class, the two return-address adjustments and how they combine, the mask and FD rewrite, and the holding of the event registers across idle and rejected cycles. The bench compares all of these against a model built from the requirements, using random and directed cases.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 12,
  parameter int BL_BIT    = 28,
  parameter int RB_BIT    = 29,
  parameter int MD_BIT    = 30,
  parameter int FD_BIT    = 15,
  parameter int IMASK_LSB = 4,
  parameter int IMASK_W   = 4,
  parameter int SLOT_B    = 2,
  parameter logic [XLEN-1:0]   RESET_PC    = 'hA000_0000,
  parameter logic [CODE_W-1:0] BL_OK_CODE  = 'h1E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              irq_vec_valid,
  input  logic [CODE_W-1:0] irq_vec,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              in_dslot,
  input  logic              sleeping,
  output logic [IMASK_W-1:0] imask_lvl,
  output logic              take,
  output logic              reset_req,
  output logic              sleep_clr,
  output logic              dslot_clr,
  output logic              resv_clr,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   pc_out,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);
  localparam logic [XLEN-1:0] OFS_GEN = XLEN'('h100);
  localparam logic [XLEN-1:0] OFS_TLB = XLEN'('h400);
  localparam logic [XLEN-1:0] OFS_IRQ = XLEN'('h600);
  localparam logic [XLEN-1:0] STEP    = XLEN'(SLOT_B);

  logic bl, do_exp, do_irq, exc_blk, irq_blk, pass, take_c;
  logic rst_cls, tlb_cls, trap_cls;
  logic [XLEN-1:0] spc_n, sr_n, pc_n;

  assign imask_lvl = sr_in[IMASK_LSB +: IMASK_W];
  assign bl        = sr_in[BL_BIT];
  assign do_exp    = exc_valid;
  assign do_irq    = irq_req & ~exc_valid & ~in_dslot;
  assign exc_blk   = bl & do_exp & (exc_code != BL_OK_CODE);
  assign irq_blk   = bl & do_irq & ~sleeping;
  assign pass      = (do_exp | do_irq) & ~exc_blk & ~irq_blk;
  assign take_c    = pass & (do_exp | irq_vec_valid);

  assign rst_cls  = exc_code == CODE_W'('h000) || exc_code == CODE_W'('h020) ||
                    exc_code == CODE_W'('h140);
  assign tlb_cls  = exc_code == CODE_W'('h040) || exc_code == CODE_W'('h060);
  assign trap_cls = exc_code == CODE_W'('h160);

  assign spc_n = pc_in - (in_dslot ? STEP : '0) + ((do_exp && trap_cls) ? STEP : '0);

  always_comb begin
    sr_n = sr_in;
    sr_n[BL_BIT] = 1'b1;
    sr_n[RB_BIT] = 1'b1;
    sr_n[MD_BIT] = 1'b1;
    if (do_exp && rst_cls) begin
      sr_n[FD_BIT] = 1'b0;
      sr_n[IMASK_LSB +: IMASK_W] = '1;
    end
  end

  always_comb begin
    if (!do_exp)      pc_n = vbr_in + OFS_IRQ;
    else if (rst_cls) pc_n = RESET_PC;
    else if (tlb_cls) pc_n = vbr_in + OFS_TLB;
    else              pc_n = vbr_in + OFS_GEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take <= 1'b0; reset_req <= 1'b0; sleep_clr <= 1'b0; dslot_clr <= 1'b0;
      ssr <= '0; spc <= '0; sgr <= '0; sr_out <= '0; pc_out <= '0;
      expevt <= '0; intevt <= '0;
    end else begin
      take      <= take_c;
      reset_req <= exc_blk;
      sleep_clr <= pass;
      dslot_clr <= take_c & in_dslot;
      if (take_c) begin
        ssr    <= sr_in;
        spc    <= spc_n;
        sgr    <= r15_in;
        sr_out <= sr_n;
        pc_out <= pc_n;
        if (do_exp) expevt <= exc_code;
        else        intevt <= irq_vec;
      end
    end
  end

  assign resv_clr = take;

  p_exc_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !sr_in[BL_BIT]) |=> (take && expevt == $past(exc_code)));

  p_bl_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && sr_in[BL_BIT] && exc_code != BL_OK_CODE) |=> (reset_req && !take));

  p_dslot_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !exc_valid && in_dslot) |=> !take);

  p_save_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ssr == $past(sr_in) && sr_out[BL_BIT] && sr_out[RB_BIT] && sr_out[MD_BIT]));

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && reset_req));
endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic exc_valid = 0, irq_req = 0, irq_vec_valid = 0, in_dslot = 0, sleeping = 0;
  logic [11:0] exc_code = 0, irq_vec = 0;
  logic [31:0] sr_in = 0, pc_in = 0, r15_in = 0, vbr_in = 0;
  logic [3:0] imask_lvl;
  logic take, reset_req, sleep_clr, dslot_clr, resv_clr;
  logic [31:0] ssr, spc, sgr, sr_out, pc_out;
  logic [11:0] expevt, intevt;

  exc_entry_ctrl u0 (.*);

  int checks = 0, errors = 0;
  logic [31:0] m_ssr, m_spc, m_sgr, m_sr, m_pc;
  logic [11:0] m_exp, m_int;
  logic m_take, m_rst, m_slp, m_ds;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic predict();
    logic bl, dexp, dirq, eblk, iblk, pass;
    bl   = sr_in[28];
    dexp = exc_valid;
    dirq = irq_req && !exc_valid && !in_dslot;
    eblk = bl && dexp && exc_code != 12'h1E0;
    iblk = bl && dirq && !sleeping;
    pass = (dexp || dirq) && !eblk && !iblk;
    m_take = pass && (dexp || irq_vec_valid);
    m_rst = eblk;
    m_slp = pass;
    m_ds  = m_take && in_dslot;
    if (m_take) begin
      m_ssr = sr_in; m_sgr = r15_in;
      m_sr = sr_in | 32'h7000_0000;
      m_spc = in_dslot ? pc_in - 2 : pc_in;
      if (dexp) begin
        m_exp = exc_code;
        if (exc_code == 12'h000 || exc_code == 12'h020 || exc_code == 12'h140) begin
          m_pc = 32'hA000_0000;
          m_sr = (m_sr & ~32'h0000_8000) | 32'h0000_00F0;
        end else if (exc_code == 12'h040 || exc_code == 12'h060) m_pc = vbr_in + 32'h400;
        else m_pc = vbr_in + 32'h100;
        if (exc_code == 12'h160) m_spc = m_spc + 2;
      end else begin
        m_int = irq_vec;
        m_pc = vbr_in + 32'h600;
      end
    end
  endtask

  task automatic step();
    chk("R4 imask", {28'd0, imask_lvl}, {28'd0, sr_in[7:4]});
    predict();
    @(posedge clk); #1;
    chk("R2 R3 R4 R10 R11 take", {31'd0, take}, {31'd0, m_take});
    chk("R2 reset_req", {31'd0, reset_req}, {31'd0, m_rst});
    chk("R12 sleep_clr", {31'd0, sleep_clr}, {31'd0, m_slp});
    chk("R6 dslot_clr", {31'd0, dslot_clr}, {31'd0, m_ds});
    chk("R5 resv_clr", {31'd0, resv_clr}, {31'd0, m_take});
    chk("R5 ssr", ssr, m_ssr);
    chk("R5 sgr", sgr, m_sgr);
    chk("R5 R7 sr_out", sr_out, m_sr);
    chk("R6 R8 spc", spc, m_spc);
    chk("R7 R8 R9 pc_out", pc_out, m_pc);
    chk("R1 expevt", {20'd0, expevt}, {20'd0, m_exp});
    chk("R1 R9 intevt", {20'd0, intevt}, {20'd0, m_int});
  endtask

  task automatic drive(logic ev, logic [11:0] code, logic ir, logic vv, logic [11:0] vec,
                       logic [31:0] sr, logic ds, logic slp);
    exc_valid = ev; exc_code = code; irq_req = ir; irq_vec_valid = vv; irq_vec = vec;
    sr_in = sr; in_dslot = ds; sleeping = slp;
    pc_in = 32'h0C00_1000 + {$urandom_range(0, 255), 1'b0};
    r15_in = $urandom; vbr_in = {$urandom_range(0, 65535), 16'h0};
    step();
  endtask

  logic [11:0] codes [9] = '{12'h000, 12'h020, 12'h140, 12'h040, 12'h060,
                             12'h160, 12'h1E0, 12'h180, 12'h0E0};

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ssr = 0; m_spc = 0; m_sgr = 0; m_sr = 0; m_pc = 0; m_exp = 0; m_int = 0;
    #7 rst_n = 1'b1;
    #1;
    chk("R11 reset take", {31'd0, take}, 32'd0);
    chk("R11 reset pc", pc_out, 32'd0);
    // R1: exception beats interrupt
    drive(1, 12'h180, 1, 1, 12'h3A0, 32'h0000_0050, 0, 0);
    // R9: plain interrupt
    drive(0, 0, 1, 1, 12'h320, 32'h0000_0030, 0, 0);
    // R4: no valid vector
    drive(0, 0, 1, 0, 12'h321, 32'h0000_0030, 0, 0);
    // R2: blocked exception, then allowed code
    drive(1, 12'h040, 0, 0, 0, 32'h1000_0000, 0, 0);
    drive(1, 12'h1E0, 0, 0, 0, 32'h1000_0000, 0, 0);
    // R3: BL masks irq unless sleeping
    drive(0, 0, 1, 1, 12'h400, 32'h1000_0000, 0, 0);
    drive(0, 0, 1, 1, 12'h420, 32'h1000_0000, 0, 1);
    // R10: irq in delay slot
    drive(0, 0, 1, 1, 12'h440, 32'h0, 1, 0);
    // R6 R8: TRAPA in delay slot
    drive(1, 12'h160, 0, 0, 0, 32'h0, 1, 0);
    // R7: reset-class clears FD, sets mask
    drive(1, 12'h020, 0, 0, 0, 32'h0000_8000, 0, 0);
    // idle hold R11
    drive(0, 0, 0, 0, 0, 32'h0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] sr;
      sr = $urandom;
      sr[28] = ($urandom_range(0, 9) < 4);
      drive($urandom_range(0, 1), codes[$urandom_range(0, 8)], $urandom_range(0, 1),
            ($urandom_range(0, 3) != 0), 12'($urandom), sr,
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) < 3));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule